// File: doc/BRIEF.md
# Masked Vector Element Blend Unit

This block forms a 512-bit result vector by picking each lane from one of two 512-bit source vectors. A 16-bit per-lane mask makes the choice. Lanes are 32 or 64 bits wide, and the active vector length is 128, 256 or 512 bits. Everything at and above the active length is cleared.

Lanes whose mask bit is clear either keep the source-1 element (merge) or are cleared (zero mode). A mask-absent flag makes every active lane take source 2 whatever the mask holds. A broadcast flag replaces each selected lane with the lowest source-2 element. This models a scalar operand that has been replicated. Lane contents are copied as raw bit patterns. No floating-point interpretation, rounding or exception takes place.

One request is taken per valid/ready transfer. The result is held in an output register until it is consumed downstream.

Top module: `mask_blend_unit`

## Requirements
- R1: In merge mode (zero_mode_i=0, no_mask_i=0), an active lane j with mask_i[j]=1 takes the source-2 element of lane j. An active lane with mask_i[j]=0 takes the source-1 element of lane j.
- R2: With zero_mode_i=1 and no_mask_i=0, every active lane whose mask bit is 0 is output as all zeros.
- R3: With no_mask_i=1, every active lane takes its source-2 value (or the broadcast value) regardless of mask_i and zero_mode_i.
- R4: With bcast_i=1, every lane that selects source 2 receives src2_i[31:0] (32-bit lanes) or src2_i[63:0] (64-bit lanes). Lanes that do not select source 2 follow R1/R2.
- R5: lane64_i=0 selects 32-bit lanes, so lane j is bits [32j+31:32j] and uses mask_i[j]. lane64_i=1 selects 64-bit lanes, so lane j is bits [64j+63:64j] and uses mask_i[j].
- R6: vlen_i=2'b00 gives 128 bits, 2'b01 gives 256 bits, and 2'b10 or 2'b11 gives 512 bits. All output bits at and above the active length are zero.
- R7: Mask bits at or above the active lane count (4/8/16 lanes for 32-bit, 2/4/8 lanes for 64-bit) have no effect on the output.
- R8: Lane contents pass through bit-exact, including NaN, infinity and denormal patterns.
- R9: A request is accepted on a rising edge where in_valid_i and in_ready_o are both high. out_valid_o rises after that edge with the result. The result and out_valid_o hold while out_ready_i is low, and in_ready_o is low while a result waits unconsumed.
- R10: Asserting rst_ni low clears out_valid_o and out_data_o at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request valid |
| in_ready_o | output | 1 | Request can be accepted |
| src1_i | input | 512 | First source vector |
| src2_i | input | 512 | Second source vector |
| mask_i | input | 16 | Per-lane select mask, bit j for lane j |
| lane64_i | input | 1 | 0: 32-bit lanes, 1: 64-bit lanes |
| vlen_i | input | 2 | Active length: 00=128, 01=256, 10/11=512 |
| zero_mode_i | input | 1 | Clear unselected lanes instead of merging |
| no_mask_i | input | 1 | Ignore mask, select source 2 in all active lanes |
| bcast_i | input | 1 | Replicate lowest source-2 element into selected lanes |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Result consumed |
| out_data_o | output | 512 | Result vector |

## Verification
The bench builds the block with its default parameters: a 512-bit vector, 32-bit slots and a 128-bit minimum length. These defaults reach every combination of lane width and vector-length code, including the reserved length code. They also reach the cases where mask bits fall beyond the active lane count. Table rows mix merge, zero, mask-absent and broadcast modes with raw NaN-like data. The expected vectors come from a lane-wise model written from the requirements. Directed tests then cover back-pressure holding, in_ready_o dropping and an asynchronous reset while a result is held.

// File: rtl/mask_blend_pkg.sv
package mask_blend_pkg;

  typedef enum logic [1:0] {
    VL_128  = 2'b00,
    VL_256  = 2'b01,
    VL_512  = 2'b10,
    VL_RSVD = 2'b11
  } vlen_e;

  typedef struct packed {
    logic  lane64;
    vlen_e vlen;
    logic  zero_mode;
    logic  no_mask;
    logic  bcast;
  } blend_ctrl_t;

  // number of active slots; reserved length code behaves as the widest one
  function automatic int active_slots(vlen_e vl, int base);
    int sh;
    sh = (vl == VL_RSVD) ? 2 : int'(vl);
    return base << sh;
  endfunction

endpackage

// File: rtl/mbu_slot_ctrl.sv
module mbu_slot_ctrl
  import mask_blend_pkg::*;
#(
  parameter int NSLOT      = 16,
  parameter int BASE_SLOTS = 4
) (
  input  blend_ctrl_t      ctrl_i,
  input  logic [NSLOT-1:0] mask_i,
  output logic [NSLOT-1:0] take2_o,
  output logic [NSLOT-1:0] zero_o
);

  int n_act;
  assign n_act = active_slots(ctrl_i.vlen, BASE_SLOTS);

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic lane_bit, active;
    // 64-bit lanes span two slots sharing one mask bit
    assign lane_bit = ctrl_i.lane64 ? mask_i[s/2] : mask_i[s];
    assign active   = (s < n_act);
    assign take2_o[s] = active & (ctrl_i.no_mask | lane_bit);
    assign zero_o[s]  = ~active | (~take2_o[s] & ctrl_i.zero_mode);
  end

endmodule

// File: rtl/mbu_datapath.sv
module mbu_datapath #(
  parameter int NSLOT  = 16,
  parameter int SLOT_W = 32,
  localparam int VW    = NSLOT * SLOT_W
) (
  input  logic [VW-1:0]    src1_i,
  input  logic [VW-1:0]    src2_i,
  input  logic [NSLOT-1:0] take2_i,
  input  logic [NSLOT-1:0] zero_i,
  input  logic             lane64_i,
  input  logic             bcast_i,
  output logic [VW-1:0]    res_o
);

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic [SLOT_W-1:0] s1, s2_own, s2_bc, s2_sel;
    assign s1     = src1_i[s*SLOT_W +: SLOT_W];
    assign s2_own = src2_i[s*SLOT_W +: SLOT_W];
    // broadcast: low element, half chosen by slot parity for 64-bit lanes
    assign s2_bc  = lane64_i ? src2_i[(s%2)*SLOT_W +: SLOT_W] : src2_i[SLOT_W-1:0];
    assign s2_sel = bcast_i ? s2_bc : s2_own;
    assign res_o[s*SLOT_W +: SLOT_W] = zero_i[s]  ? '0     :
                                       take2_i[s] ? s2_sel : s1;
  end

endmodule

// File: rtl/mbu_out_stage.sv
module mbu_out_stage #(
  parameter int DW = 512
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [DW-1:0] d_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [DW-1:0] q_o
);

  logic accept;
  assign in_ready_o = ~out_valid_o | out_ready_i;
  assign accept     = in_valid_i & in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      q_o         <= '0;
    end else begin
      if (accept) begin
        out_valid_o <= 1'b1;
        q_o         <= d_i;
      end else if (out_ready_i) begin
        out_valid_o <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/mask_blend_unit.sv
module mask_blend_unit
  import mask_blend_pkg::*;
#(
  parameter int VEC_W    = 512,
  parameter int SLOT_W   = 32,
  parameter int MIN_VL_W = 128,
  localparam int NSLOT      = VEC_W / SLOT_W,
  localparam int BASE_SLOTS = MIN_VL_W / SLOT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [VEC_W-1:0] src1_i,
  input  logic [VEC_W-1:0] src2_i,
  input  logic [NSLOT-1:0] mask_i,
  input  logic             lane64_i,
  input  logic [1:0]       vlen_i,
  input  logic             zero_mode_i,
  input  logic             no_mask_i,
  input  logic             bcast_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [VEC_W-1:0] out_data_o
);

  blend_ctrl_t      ctrl;
  logic [NSLOT-1:0] take2, zero;
  logic [VEC_W-1:0] res;

  assign ctrl.lane64    = lane64_i;
  assign ctrl.vlen      = vlen_e'(vlen_i);
  assign ctrl.zero_mode = zero_mode_i;
  assign ctrl.no_mask   = no_mask_i;
  assign ctrl.bcast     = bcast_i;

  mbu_slot_ctrl #(.NSLOT(NSLOT), .BASE_SLOTS(BASE_SLOTS)) u_ctrl (
    .ctrl_i  (ctrl),
    .mask_i  (mask_i),
    .take2_o (take2),
    .zero_o  (zero)
  );

  mbu_datapath #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_dp (
    .src1_i   (src1_i),
    .src2_i   (src2_i),
    .take2_i  (take2),
    .zero_i   (zero),
    .lane64_i (lane64_i),
    .bcast_i  (bcast_i),
    .res_o    (res)
  );

  mbu_out_stage #(.DW(VEC_W)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .d_i         (res),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .q_o         (out_data_o)
  );

endmodule

// File: rtl/mask_blend_unit_chk.sv
module mask_blend_unit_chk #(
  parameter int VEC_W    = 512,
  parameter int SLOT_W   = 32,
  parameter int MIN_VL_W = 128,
  localparam int NSLOT   = VEC_W / SLOT_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic [NSLOT-1:0] mask_i,
  input logic             lane64_i,
  input logic [1:0]       vlen_i,
  input logic             zero_mode_i,
  input logic             no_mask_i,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [VEC_W-1:0] out_data_o
);

  logic [VEC_W-1:0] above_q, zlane_q, above_d, zlane_d;

  always_comb begin
    int act_bits;
    logic mb;
    act_bits = MIN_VL_W << ((vlen_i == 2'b11) ? 2 : int'(vlen_i));
    above_d = '0;
    zlane_d = '0;
    for (int s = 0; s < NSLOT; s++) begin
      mb = lane64_i ? mask_i[s/2] : mask_i[s];
      if (s * SLOT_W >= act_bits) above_d[s*SLOT_W +: SLOT_W] = '1;
      else if (zero_mode_i && !no_mask_i && !mb) zlane_d[s*SLOT_W +: SLOT_W] = '1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      above_q <= '0;
      zlane_q <= '0;
    end else if (in_valid_i && in_ready_o) begin
      above_q <= above_d;
      zlane_q <= zlane_d;
    end
  end

  p_accept_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> out_valid_o);

  p_hold_result_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  p_stall_ready_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);

  p_upper_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ((out_data_o & above_q) == '0));

  p_zero_lane_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ((out_data_o & zlane_q) == '0));

  p_reset_clear_r10: assert property (@(posedge clk_i)
    !rst_ni |-> (!out_valid_o && out_data_o == '0));

endmodule

bind mask_blend_unit mask_blend_unit_chk #(
  .VEC_W(VEC_W), .SLOT_W(SLOT_W), .MIN_VL_W(MIN_VL_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .mask_i      (mask_i),
  .lane64_i    (lane64_i),
  .vlen_i      (vlen_i),
  .zero_mode_i (zero_mode_i),
  .no_mask_i   (no_mask_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o)
);

// File: tb/mask_blend_unit_tb_top.sv
module mask_blend_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 16;

  typedef struct packed {
    logic        lane64;
    logic [1:0]  vl;
    logic        zm;
    logic        nm;
    logic        bc;
    logic [15:0] mask;
    logic [1:0]  pat;
  } vec_t;

  // lane64, vl, zero, nomask, bcast, mask, data pattern
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 16'hA5C3, 2'd0},  // R1 merge 32-bit
    '{1'b0, 2'b10, 1'b1, 1'b0, 1'b0, 16'hA5C3, 2'd0},  // R2 zero 32-bit
    '{1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 16'h0096, 2'd0},  // R5 merge 64-bit
    '{1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 16'h005A, 2'd2},  // R2 zero 64-bit
    '{1'b0, 2'b10, 1'b1, 1'b1, 1'b0, 16'h0000, 2'd0},  // R3 mask absent
    '{1'b1, 2'b01, 1'b1, 1'b1, 1'b0, 16'h0000, 2'd2},  // R3 mask absent 256
    '{1'b0, 2'b10, 1'b0, 1'b0, 1'b1, 16'h0F0F, 2'd0},  // R4 bcast 32-bit
    '{1'b1, 2'b10, 1'b1, 1'b0, 1'b1, 16'h00C3, 2'd0},  // R4 bcast 64-bit zero
    '{1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 16'hFFF5, 2'd0},  // R7 high mask bits
    '{1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 16'h0005, 2'd0},  // R7 reference
    '{1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 16'hFFFE, 2'd2},  // R6 128 64-bit
    '{1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 16'h00FF, 2'd2},  // R6 256 32-bit
    '{1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 16'h0033, 2'd0},  // R6 reserved code
    '{1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 16'h3C3C, 2'd1},  // R8 raw NaN bits
    '{1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 16'h00F0, 2'd1},  // R8 raw 64-bit
    '{1'b0, 2'b01, 1'b0, 1'b1, 1'b1, 16'h1234, 2'd1}   // R4 bcast + R3
  };

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         in_valid = 1'b0, in_ready;
  logic [511:0] src1 = '0, src2 = '0;
  logic [15:0]  mask = '0;
  logic         lane64 = 1'b0, zm = 1'b0, nm = 1'b0, bc = 1'b0;
  logic [1:0]   vl = 2'b00;
  logic         out_valid, out_ready = 1'b1;
  logic [511:0] out_data;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mask_blend_unit dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .src1_i(src1), .src2_i(src2), .mask_i(mask), .lane64_i(lane64), .vlen_i(vl),
    .zero_mode_i(zm), .no_mask_i(nm), .bcast_i(bc),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data)
  );

  function automatic logic [511:0] gen_src(logic [1:0] pat, bit second);
    logic [511:0] v;
    for (int s = 0; s < 16; s++) begin
      case (pat)
        2'd1:    v[s*32 +: 32] = second ? (32'h7FC0_0001 + 32'(s)) : (32'h8000_0001 ^ 32'(s << 4));
        2'd2:    v[s*32 +: 32] = second ? {16'hC0DE, 8'(s), 8'h5A} : {16'hFACE, 8'(s), 8'hA5};
        default: v[s*32 +: 32] = second ? {8'hB2, 8'(s), 16'h2222} : {8'hA1, 8'(s), 16'h1111};
      endcase
    end
    return v;
  endfunction

  // lane-wise reference from the requirements
  function automatic logic [511:0] model(vec_t v, logic [511:0] a, logic [511:0] b);
    logic [511:0] r;
    int act;
    bit sel;
    r = '0;
    act = 128 << ((v.vl == 2'b11) ? 2 : int'(v.vl));
    if (v.lane64) begin
      for (int j = 0; j < 8; j++) begin
        if (j * 64 < act) begin
          sel = v.nm || v.mask[j];
          if (sel)       r[j*64 +: 64] = v.bc ? b[63:0] : b[j*64 +: 64];
          else if (!v.zm) r[j*64 +: 64] = a[j*64 +: 64];
        end
      end
    end else begin
      for (int j = 0; j < 16; j++) begin
        if (j * 32 < act) begin
          sel = v.nm || v.mask[j];
          if (sel)       r[j*32 +: 32] = v.bc ? b[31:0] : b[j*32 +: 32];
          else if (!v.zm) r[j*32 +: 32] = a[j*32 +: 32];
        end
      end
    end
    return r;
  endfunction

  task automatic check(string tag, logic [511:0] act, logic [511:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(vec_t v);
    src1 = gen_src(v.pat, 1'b0);
    src2 = gen_src(v.pat, 1'b1);
    mask = v.mask; lane64 = v.lane64; vl = v.vl;
    zm = v.zm; nm = v.nm; bc = v.bc;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [511:0] exp_a, exp_b;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 reset out_valid", 512'(out_valid), 512'(0));
    check("R10 reset data", out_data, '0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R9 idle in_ready", 512'(in_ready), 512'(1));

    for (int k = 0; k < NVEC; k++) begin
      drive(VECS[k]);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("R9 row%0d out_valid", k), 512'(out_valid), 512'(1));
      check($sformatf("R1-table row%0d data", k), out_data,
            model(VECS[k], gen_src(VECS[k].pat, 1'b0), gen_src(VECS[k].pat, 1'b1)));
      @(negedge clk);
    end

    // R9 back-pressure: result A held, B waits
    exp_a = model(VECS[0], gen_src(VECS[0].pat, 1'b0), gen_src(VECS[0].pat, 1'b1));
    exp_b = model(VECS[3], gen_src(VECS[3].pat, 1'b0), gen_src(VECS[3].pat, 1'b1));
    out_ready = 1'b0;
    drive(VECS[0]);
    in_valid = 1'b1;
    @(negedge clk);
    drive(VECS[3]);
    for (int c = 0; c < 3; c++) begin
      check("R9 stall in_ready", 512'(in_ready), 512'(0));
      check("R9 stall hold data", out_data, exp_a);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 next valid", 512'(out_valid), 512'(1));
    check("R9 next data", out_data, exp_b);
    @(negedge clk);
    check("R9 drained", 512'(out_valid), 512'(0));

    // R10 asynchronous reset while a result is held
    out_ready = 1'b0;
    drive(VECS[1]);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    #(CLK_PERIOD/4);
    rst_ni = 1'b0;
    #1;
    check("R10 async valid", 512'(out_valid), 512'(0));
    check("R10 async data", out_data, '0);
    @(negedge clk);
    rst_ni = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule